// File: doc/BRIEF.md
# Partitioned SIMD Adder

This block adds or subtracts two 64-bit packed operands whose carry chain is split into independent lanes. A two-bit lane-size select picks eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or a single 64-bit lane. Each lane works on its own slice of both operands. The carry out of the top bit of a lane is dropped, and no carry or borrow enters the next lane up. Each lane result wraps modulo its own width.

Two further operations copy the low 32 bits of one operand into the result and clear the upper half. This serves as a zero-extending 32-bit move into the packed register, or as the extraction of its low word. The result is computed combinationally from the inputs and captured by one output register. It appears on the output one clock after the inputs are presented.

Top module: `simd_lane_adder`

## Requirements
- R1: While rst_n is low at a rising clock edge, result becomes 0. Otherwise result takes the value computed from the inputs sampled at that edge, so each operation shows on the output one clock after it is applied.
- R2: With op_sel=0 (add) and lane_sel=0, result bits [8k+7:8k] for k=0..7 hold (A+B) mod 2^8 of the matching byte slices. No carry passes between bytes.
- R3: With op_sel=0 and lane_sel=1, result bits [16k+15:16k] for k=0..3 hold the 16-bit lane sum mod 2^16. No carry passes between lanes.
- R4: With op_sel=0 and lane_sel=2, result bits [32k+31:32k] for k=0..1 hold the 32-bit lane sum mod 2^32. No carry passes from bit 31 into bit 32.
- R5: With op_sel=0 and lane_sel=3, result is (A+B) mod 2^64.
- R6: With op_sel=1 (subtract), each lane selected by lane_sel (same encodings as R2 to R5) holds (A-B) mod 2^w for its width w, computed as A plus inverted B plus one. No borrow passes between lanes.
- R7: With op_sel=2, result is {32'h0, A[31:0]}. op_b and lane_sel have no effect.
- R8: With op_sel=3, result is {32'h0, B[31:0]}. op_a and lane_sel have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | 64 | Packed operand A |
| op_b | input | 64 | Packed operand B |
| lane_sel | input | 2 | Lane size: 0=8-bit, 1=16-bit, 2=32-bit, 3=64-bit |
| op_sel | input | 2 | 0=add, 1=subtract, 2=move low A, 3=move low B |
| result | output | 64 | Registered packed result |

## Verification
The assertions assume that op_a, op_b, lane_sel and op_sel are known values whenever rst_n is high at a clock edge. They also assume each input set is held through the edge that samples it, because every property compares the output with the inputs of the previous edge. The bench drives all inputs only on falling edges from tasks, and it never leaves an input undriven after reset. All four lane sizes and all four operations are therefore exercised with defined values. The operand patterns include all-ones plus one, lane sign-bit overflow and zero minus one, which push carries and borrows against every lane boundary.

// File: rtl/simd_add_pkg.sv
// Shared parameters and encodings for the partitioned SIMD adder.
// Assumes the data width is a whole number of granules and that the
// granule count is a power of two no larger than 2**3.
package simd_add_pkg;
    localparam int unsigned DATA_W = 64;
    localparam int unsigned GRAN_W = 8;
    localparam int unsigned N_GRAN = DATA_W / GRAN_W;
    localparam int unsigned SEL_W  = 2;

    typedef enum logic [SEL_W-1:0] {
        LANE_8  = 2'd0,
        LANE_16 = 2'd1,
        LANE_32 = 2'd2,
        LANE_64 = 2'd3
    } lane_e;

    typedef enum logic [SEL_W-1:0] {
        OP_ADD  = 2'd0,
        OP_SUB  = 2'd1,
        OP_MOVA = 2'd2,
        OP_MOVB = 2'd3
    } op_e;
endpackage

// File: rtl/lane_boundary_dec.sv
// Marks which granules start a new lane for the selected lane size.
// A lane spans 2**lane_sel granules; granule i starts a lane when its
// index is a multiple of that span. Assumes N_GRAN is a power of two.
module lane_boundary_dec #(
    parameter int unsigned N_GRAN = 8,
    parameter int unsigned SEL_W  = 2
) (
    input  logic [SEL_W-1:0]  lane_sel,
    output logic [N_GRAN-1:0] seg_start
);
    logic [N_GRAN-1:0] span_mask;

    // Purpose: low index bits that must be zero at a lane base.
    always_comb begin
        span_mask = N_GRAN'((1 << lane_sel) - 1);
    end

    genvar gi;
    generate
        for (gi = 0; gi < N_GRAN; gi++) begin : g_start
            localparam logic [N_GRAN-1:0] IDX = N_GRAN'(gi);
            // Purpose: flag granule gi as the base of a lane.
            always_comb begin
                seg_start[gi] = ((IDX & span_mask) == '0);
            end
        end
    endgenerate
endmodule

// File: rtl/seg_adder.sv
// One granule of the carry chain: a plain ripple adder with carry in
// and carry out. Operand B arrives already inverted for subtraction.
module seg_adder #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    // Purpose: add the granule slices with the incoming carry.
    always_comb begin
        {cout, sum} = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    end
endmodule

// File: rtl/simd_lane_adder.sv
// Partitioned 64-bit adder/subtractor with zero-extending low-word moves.
// The carry chain is cut into granules; at each lane base the carry in
// is forced to the subtract flag rather than taken from the granule
// below. The result is registered once; reset is synchronous, active low.
module simd_lane_adder
    import simd_add_pkg::*;
#(
    parameter int unsigned P_DATA_W = DATA_W,
    parameter int unsigned P_GRAN_W = GRAN_W,
    localparam int unsigned P_NGRAN = P_DATA_W / P_GRAN_W,
    localparam int unsigned HALF_W  = P_DATA_W / 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [P_DATA_W-1:0] op_a,
    input  logic [P_DATA_W-1:0] op_b,
    input  logic [1:0]          lane_sel,
    input  logic [1:0]          op_sel,
    output logic [P_DATA_W-1:0] result
);
    logic                is_sub;
    logic [P_DATA_W-1:0] b_eff;
    logic [P_DATA_W-1:0] lane_sum;
    logic [P_DATA_W-1:0] next_result;
    logic [P_NGRAN-1:0]  seg_start;
    logic [P_NGRAN-1:0]  seg_cin;
    logic [P_NGRAN-1:0]  seg_cout;

    // Purpose: choose add or subtract and condition operand B.
    always_comb begin
        is_sub = (op_sel == OP_SUB);
        b_eff  = is_sub ? ~op_b : op_b;
    end

    lane_boundary_dec #(
        .N_GRAN (P_NGRAN),
        .SEL_W  (2)
    ) u_bound (
        .lane_sel  (lane_sel),
        .seg_start (seg_start)
    );

    genvar gi;
    generate
        for (gi = 0; gi < P_NGRAN; gi++) begin : g_seg
            if (gi == 0) begin : g_base
                // Purpose: the lowest granule always starts a lane.
                always_comb seg_cin[gi] = is_sub;
            end else begin : g_link
                // Purpose: block or pass the carry at this granule edge.
                always_comb seg_cin[gi] = seg_start[gi] ? is_sub : seg_cout[gi-1];
            end

            seg_adder #(
                .W (P_GRAN_W)
            ) u_seg (
                .a    (op_a[gi*P_GRAN_W +: P_GRAN_W]),
                .b    (b_eff[gi*P_GRAN_W +: P_GRAN_W]),
                .cin  (seg_cin[gi]),
                .sum  (lane_sum[gi*P_GRAN_W +: P_GRAN_W]),
                .cout (seg_cout[gi])
            );
        end
    endgenerate

    // Purpose: select the arithmetic result or a zero-extended low word.
    always_comb begin
        unique case (op_sel)
            OP_MOVA: next_result = {{HALF_W{1'b0}}, op_a[HALF_W-1:0]};
            OP_MOVB: next_result = {{HALF_W{1'b0}}, op_b[HALF_W-1:0]};
            default: next_result = lane_sum;
        endcase
    end

    // Purpose: capture the result, cleared by synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) result <= '0;
        else        result <= next_result;
    end
endmodule

// File: rtl/simd_lane_adder_chk.sv
// Property checker for simd_lane_adder, attached with bind. Computes a
// bit-serial reference with carries restarted at lane bases, and checks
// the registered output one clock after each operation.
module simd_lane_adder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [63:0] op_a,
    input logic [63:0] op_b,
    input logic [1:0]  lane_sel,
    input logic [1:0]  op_sel,
    input logic [63:0] result
);
    function automatic logic [63:0] serial_ref(input logic [63:0] a,
                                               input logic [63:0] b,
                                               input int          w,
                                               input logic        sub);
        logic [63:0] r;
        logic c;
        logic bb;
        r = '0;
        c = sub;
        for (int i = 0; i < 64; i++) begin
            if (i % w == 0) c = sub;
            bb   = b[i] ^ sub;
            r[i] = a[i] ^ bb ^ c;
            c    = (a[i] & bb) | (c & (a[i] ^ bb));
        end
        return r;
    endfunction

    function automatic int lane_width(input logic [1:0] sel);
        return 8 << sel;
    endfunction

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (result == 64'h0));

    a_r2_byte_add: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'd0 && lane_sel == 2'd0)
        |=> (result == serial_ref($past(op_a), $past(op_b), 8, 1'b0)));

    a_r3_word_add: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'd0 && lane_sel == 2'd1)
        |=> (result == serial_ref($past(op_a), $past(op_b), 16, 1'b0)));

    a_r4_dword_add: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'd0 && lane_sel == 2'd2)
        |=> (result == serial_ref($past(op_a), $past(op_b), 32, 1'b0)));

    a_r5_quad_add: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'd0 && lane_sel == 2'd3)
        |=> (result == $past(op_a) + $past(op_b)));

    a_r6_lane_sub: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'd1)
        |=> (result == serial_ref($past(op_a), $past(op_b),
                                  lane_width($past(lane_sel)), 1'b1)));

    a_r7_move_a_low: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'd2)
        |=> (result[63:32] == 32'h0 && result[31:0] == $past(op_a[31:0])));

    a_r8_move_b_low: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'd3)
        |=> (result[63:32] == 32'h0 && result[31:0] == $past(op_b[31:0])));
endmodule

bind simd_lane_adder simd_lane_adder_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_a     (op_a),
    .op_b     (op_b),
    .lane_sel (lane_sel),
    .op_sel   (op_sel),
    .result   (result)
);

// File: tb/simd_lane_adder_tb.sv
`timescale 1ns/1ps
module simd_lane_adder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [1:0]  lane_sel = '0;
    logic [1:0]  op_sel = '0;
    logic [63:0] result;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    simd_lane_adder u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_a     (op_a),
        .op_b     (op_b),
        .lane_sel (lane_sel),
        .op_sel   (op_sel),
        .result   (result)
    );

    // Behavioural model: lane arithmetic on unsigned 64-bit integers.
    function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                          input logic [1:0] ls, input logic [1:0] op);
        longint unsigned res, mask, la, lb, r;
        int w;
        if (op == 2'd2) return {32'h0, a[31:0]};
        if (op == 2'd3) return {32'h0, b[31:0]};
        w    = 8 << ls;
        mask = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
        res  = 0;
        for (int k = 0; k < 64 / w; k++) begin
            la  = (a >> (k * w)) & mask;
            lb  = (b >> (k * w)) & mask;
            r   = (op == 2'd1) ? (la - lb) : (la + lb);
            res = res | ((r & mask) << (k * w));
        end
        return res;
    endfunction

    task automatic check(input string req, input logic [63:0] exp);
        total++;
        if (result !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, result, exp);
        end
    endtask

    task automatic step(input string req, input logic [63:0] a, input logic [63:0] b,
                        input logic [1:0] ls, input logic [1:0] op);
        logic [63:0] exp;
        @(negedge clk);
        op_a = a; op_b = b; lane_sel = ls; op_sel = op;
        exp = model(a, b, ls, op);
        @(posedge clk);
        #1;
        check(req, exp);
    endtask

    initial begin
        #200000;
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] held;
        // R1: reset clears the output even with active inputs
        op_a = 64'hFFFF_FFFF_FFFF_FFFF; op_b = 64'h1; op_sel = 2'd0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", 64'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: byte lanes, carry blocked at each byte boundary
        step("R2", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 2'd0, 2'd0);
        step("R2", 64'h807F_1234_00FF_8080, 64'h8001_4321_FF01_8080, 2'd0, 2'd0);
        // R3: word lanes
        step("R3", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0001_0001_0001, 2'd1, 2'd0);
        step("R3", 64'h00FF_7FFF_8000_1234, 64'h0001_0001_8000_EDCC, 2'd1, 2'd0);
        // R4: doubleword lanes
        step("R4", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, 2'd2, 2'd0);
        step("R4", 64'h1234_5678_FFFF_0000, 64'h1111_1111_0001_0000, 2'd2, 2'd0);
        // R5: full 64-bit lane, carry crosses every granule
        step("R5", 64'h00FF_FFFF_FFFF_FFFF, 64'h1, 2'd3, 2'd0);
        step("R5", 64'hFFFF_FFFF_FFFF_FFFF, 64'h2, 2'd3, 2'd0);
        // R6: subtraction in every lane size, borrow blocked at lane bases
        step("R6", 64'h0, 64'h0101_0101_0101_0101, 2'd0, 2'd1);
        step("R6", 64'h0000_0100_0000_0000, 64'h0001_0001_0001_0001, 2'd1, 2'd1);
        step("R6", 64'h0000_0001_0000_0000, 64'h0000_0000_0000_0001, 2'd2, 2'd1);
        step("R6", 64'h0000_0001_0000_0000, 64'h0000_0000_0000_0001, 2'd3, 2'd1);
        step("R6", 64'h7F80_0001_DEAD_BEEF, 64'h80FF_0002_BEEF_DEAD, 2'd0, 2'd1);
        // R7: zero-extending move of A low word, B and lane size ignored
        step("R7", 64'hAAAA_BBBB_CCCC_DDDD, 64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 2'd2);
        step("R7", 64'h1234_5678_9ABC_DEF0, 64'h0123_4567_89AB_CDEF, 2'd3, 2'd2);
        // R8: zero-extending move of B low word, A and lane size ignored
        step("R8", 64'hFFFF_FFFF_FFFF_FFFF, 64'h5555_6666_7777_8888, 2'd1, 2'd3);
        step("R8", 64'h0, 64'hFEDC_BA98_7654_3210, 2'd2, 2'd3);

        // R1: output holds until the next edge after new inputs appear
        @(negedge clk);
        held = result;
        op_a = 64'h1; op_b = 64'h1; lane_sel = 2'd3; op_sel = 2'd0;
        #1;
        check("R1 latency", held);
        @(posedge clk);
        #1;
        check("R1 latency", 64'h2);

        // R1: synchronous reset mid-run clears the register
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1 reset", 64'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // mixed operations back to back
        for (int i = 0; i < 40; i++) begin
            logic [63:0] a, b;
            a = {$urandom(), $urandom()};
            b = {$urandom(), $urandom()};
            step("R2..R8 mix", a, b, 2'(i), 2'(i >> 2));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule